// File: doc/BRIEF.md
# Conditional branch resolver

This block resolves one 16-bit compact conditional branch instruction per cycle. The caller presents the instruction word, the current program counter value and the four condition flags (negative, zero, carry, overflow). The block evaluates the condition field against the flags and decides whether the branch is taken.

When the branch is taken, the block adds the signed, halfword-scaled displacement to the program counter. It returns that sum as the next fetch address, and returns the same sum plus 2 as the new program counter value. The taken flag also tells the caller to refill the pipeline and clear its prefetch count. The block also reports the cycle cost of the instruction, built from three access costs that the caller supplies. The two condition codes that are not branches are passed back as flags and are not resolved. Words that do not carry the branch major opcode are ignored.

All results come out of one register stage, one cycle after the instruction is accepted.

Top module: `cbr_resolver`

## Requirements
- R1: While reset is high, `out_valid`, `out_taken`, `out_undef` and `out_swi` are 0 and `out_cycles` is 0, whatever the inputs are.
- R2: A word with `in_insn[15:12] == 4'b1101`, presented with `in_valid` high, gives `out_valid` high in the next cycle. Any other word, and any cycle with `in_valid` low, gives `out_valid` low in the next cycle. When `out_valid` is low, `out_taken`, `out_undef` and `out_swi` are all 0.
- R3: The condition field is `in_insn[11:8]`. Codes 0 through 7 are taken, in that order, when: Z set, Z clear, C set, C clear, N set, N clear, V set, V clear.
- R4: Code 8 is taken when C is set and Z is clear. Code 9 is taken when C is clear or Z is set.
- R5: Code 10 is taken when N equals V. Code 11 is taken when N differs from V.
- R6: Code 12 is taken when Z is clear and N equals V. Code 13 is taken when Z is set or N differs from V.
- R7: For a taken branch, `out_fetch_addr` is `in_pc + (sign-extended in_insn[7:0] << 1)`, computed modulo 2^AW. `out_pc_next` is `out_fetch_addr + 2`.
- R8: For a branch that is not taken, and for codes 14 and 15, `out_fetch_addr` and `out_pc_next` both equal `in_pc`.
- R9: A branch that is not taken costs `cost_base` cycles. A taken branch costs `cost_base + cost_nseq + cost_seq + 2` cycles, with no truncation.
- R10: Code 14 raises `out_undef` and code 15 raises `out_swi`. For either code, `out_taken` is 0 and `out_cycles` is 0.
- R11: At most one of `out_taken`, `out_undef` and `out_swi` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction presented this cycle |
| in_insn | input | 16 | Instruction word |
| in_pc | input | AW | Current program counter value |
| in_flag_n | input | 1 | Negative flag |
| in_flag_z | input | 1 | Zero flag |
| in_flag_c | input | 1 | Carry flag |
| in_flag_v | input | 1 | Overflow flag |
| cost_base | input | CW | Cost of a single instruction |
| cost_nseq | input | CW | Cost of a non-sequential code access |
| cost_seq | input | CW | Cost of a sequential code access |
| out_valid | output | 1 | Result present |
| out_taken | output | 1 | Branch taken; refill the pipeline and clear the prefetch count |
| out_fetch_addr | output | AW | Next fetch address |
| out_pc_next | output | AW | New program counter value |
| out_cycles | output | CW+2 | Cycle cost |
| out_undef | output | 1 | Undefined condition code (14) |
| out_swi | output | 1 | Software interrupt code (15) |

## Verification
The bound checker looks at every cycle. It checks that the three outcome flags are exclusive and stay quiet without a result, that every result traces back to an accepted input, and that a taken result has its program counter 2 past the fetch address. It also checks that a result that is not taken keeps the incoming program counter, and that the cycle cost matches the taken, not-taken or exception case. Whether each of the fourteen conditions decodes correctly over all sixteen flag patterns can only be shown by the bench's sweep. The same holds for the displacement sign extension and wrap-around, and for the filtering of foreign opcodes.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

    localparam logic [3:0] BRANCH_MAJOR = 4'b1101;
    localparam logic [3:0] CODE_UNDEF   = 4'he;
    localparam logic [3:0] CODE_SWI     = 4'hf;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    typedef enum logic [1:0] {
        KIND_NONE   = 2'd0,
        KIND_BRANCH = 2'd1,
        KIND_UNDEF  = 2'd2,
        KIND_SWI    = 2'd3
    } brkind_e;

    // Base predicate for a pair of codes; the odd member is its inverse.
    function automatic logic pair_pred(input logic [2:0] pair, input flags_t f);
        logic r;
        case (pair)
            3'd0:    r = f.z;
            3'd1:    r = f.c;
            3'd2:    r = f.n;
            3'd3:    r = f.v;
            3'd4:    r = f.c & ~f.z;
            3'd5:    r = (f.n == f.v);
            3'd6:    r = ~f.z & (f.n == f.v);
            default: r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cbr_decode.sv
module cbr_decode
    import cbr_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [15:0]   insn,
    output logic [3:0]    code,
    output brkind_e       kind,
    output logic [AW-1:0] disp
);
    localparam int EXT = AW - 9;

    always_comb begin
        code = insn[11:8];
        disp = {{EXT{insn[7]}}, insn[7:0], 1'b0};
        if (insn[15:12] != BRANCH_MAJOR)
            kind = KIND_NONE;
        else if (insn[11:8] == CODE_UNDEF)
            kind = KIND_UNDEF;
        else if (insn[11:8] == CODE_SWI)
            kind = KIND_SWI;
        else
            kind = KIND_BRANCH;
    end
endmodule

// File: rtl/cbr_cond.sv
module cbr_cond
    import cbr_pkg::*;
(
    input  logic [3:0] code,
    input  flags_t     flags,
    output logic       pass
);
    logic base;

    always_comb begin
        base = pair_pred(code[3:1], flags);
        pass = base ^ code[0];
    end
endmodule

// File: rtl/cbr_cost.sv
module cbr_cost #(
    parameter int CW = 8
) (
    input  logic          charge,
    input  logic          taken,
    input  logic [CW-1:0] base,
    input  logic [CW-1:0] nseq,
    input  logic [CW-1:0] seq,
    output logic [CW+1:0] cycles
);
    localparam int YW = CW + 2;
    localparam logic [YW-1:0] REFILL_EXTRA = YW'(2);

    logic [YW-1:0] refill;

    always_comb begin
        refill = YW'(nseq) + YW'(seq) + REFILL_EXTRA;
        if (!charge)
            cycles = '0;
        else if (taken)
            cycles = YW'(base) + refill;
        else
            cycles = YW'(base);
    end
endmodule

// File: rtl/cbr_resolver.sv
module cbr_resolver
    import cbr_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [15:0]   in_insn,
    input  logic [AW-1:0] in_pc,
    input  logic          in_flag_n,
    input  logic          in_flag_z,
    input  logic          in_flag_c,
    input  logic          in_flag_v,
    input  logic [CW-1:0] cost_base,
    input  logic [CW-1:0] cost_nseq,
    input  logic [CW-1:0] cost_seq,
    output logic          out_valid,
    output logic          out_taken,
    output logic [AW-1:0] out_fetch_addr,
    output logic [AW-1:0] out_pc_next,
    output logic [CW+1:0] out_cycles,
    output logic          out_undef,
    output logic          out_swi
);
    localparam int YW = CW + 2;
    localparam logic [AW-1:0] PC_STEP = AW'(2);

    logic [3:0]    code;
    brkind_e       kind;
    logic [AW-1:0] disp;
    logic          pass;
    flags_t        flags;
    logic [YW-1:0] cost;

    logic          acc, tk;
    logic [AW-1:0] target, fetch_d, pcn_d;

    assign flags = '{n: in_flag_n, z: in_flag_z, c: in_flag_c, v: in_flag_v};

    cbr_decode #(.AW(AW)) dec_i (
        .insn (in_insn),
        .code (code),
        .kind (kind),
        .disp (disp)
    );

    cbr_cond cond_i (
        .code  (code),
        .flags (flags),
        .pass  (pass)
    );

    cbr_cost #(.CW(CW)) cost_i (
        .charge (kind == KIND_BRANCH),
        .taken  (tk),
        .base   (cost_base),
        .nseq   (cost_nseq),
        .seq    (cost_seq),
        .cycles (cost)
    );

    always_comb begin
        acc     = in_valid && (kind != KIND_NONE);
        tk      = (kind == KIND_BRANCH) && pass;
        target  = in_pc + disp;
        fetch_d = tk ? target : in_pc;
        pcn_d   = tk ? target + PC_STEP : in_pc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid      <= 1'b0;
            out_taken      <= 1'b0;
            out_undef      <= 1'b0;
            out_swi        <= 1'b0;
            out_cycles     <= '0;
            out_fetch_addr <= '0;
            out_pc_next    <= '0;
        end else begin
            out_valid      <= acc;
            out_taken      <= acc && tk;
            out_undef      <= acc && (kind == KIND_UNDEF);
            out_swi        <= acc && (kind == KIND_SWI);
            out_cycles     <= acc ? cost : '0;
            out_fetch_addr <= fetch_d;
            out_pc_next    <= pcn_d;
        end
    end
endmodule

// File: rtl/cbr_resolver_chk.sv
module cbr_resolver_chk #(
    parameter int AW = 32,
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic [AW-1:0] in_pc,
    input logic [CW-1:0] cost_base,
    input logic [CW-1:0] cost_nseq,
    input logic [CW-1:0] cost_seq,
    input logic          out_valid,
    input logic          out_taken,
    input logic [AW-1:0] out_fetch_addr,
    input logic [AW-1:0] out_pc_next,
    input logic [CW+1:0] out_cycles,
    input logic          out_undef,
    input logic          out_swi
);
    localparam int YW = CW + 2;

    AST_SINGLE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $onehot0({out_taken, out_undef, out_swi})); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !out_taken && !out_undef && !out_swi); // R2

    AST_RESULT_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid)); // R2

    AST_PC_PAST_TARGET: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_taken |-> out_pc_next == out_fetch_addr + AW'(2)); // R7

    AST_HOLD_PC: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_taken |->
            out_fetch_addr == $past(in_pc) && out_pc_next == $past(in_pc)); // R8

    AST_COST_SKIP: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_taken && !out_undef && !out_swi |->
            out_cycles == YW'($past(cost_base))); // R9

    AST_COST_TAKEN: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_taken |->
            out_cycles == YW'($past(cost_base)) + YW'($past(cost_nseq))
                          + YW'($past(cost_seq)) + YW'(2)); // R9

    AST_EXC_FREE: assert property (@(posedge clk) disable iff (rst)
        out_valid && (out_undef || out_swi) |-> out_cycles == '0); // R10
endmodule

bind cbr_resolver cbr_resolver_chk #(.AW(AW), .CW(CW)) chk_i (
    .clk            (clk),
    .rst            (rst),
    .in_valid       (in_valid),
    .in_pc          (in_pc),
    .cost_base      (cost_base),
    .cost_nseq      (cost_nseq),
    .cost_seq       (cost_seq),
    .out_valid      (out_valid),
    .out_taken      (out_taken),
    .out_fetch_addr (out_fetch_addr),
    .out_pc_next    (out_pc_next),
    .out_cycles     (out_cycles),
    .out_undef      (out_undef),
    .out_swi        (out_swi)
);

// File: tb/cbr_resolver_tb.sv
`timescale 1ns/1ps
module cbr_resolver_tb_top;
    localparam int AW = 32;
    localparam int CW = 8;

    typedef struct {
        logic        vld;
        logic        taken;
        logic        undef;
        logic        swi;
        logic [31:0] fetch;
        logic [31:0] pcn;
        logic [9:0]  cyc;
        logic [3:0]  code;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [15:0]   in_insn = '0;
    logic [AW-1:0] in_pc = '0;
    logic          fn = 0, fz = 0, fc = 0, fv = 0;
    logic [CW-1:0] cb = '0, cn = '0, cs = '0;
    logic          out_valid, out_taken, out_undef, out_swi;
    logic [AW-1:0] out_fetch_addr, out_pc_next;
    logic [CW+1:0] out_cycles;

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   mon_on = 0;
    exp_t q[$];

    always #2 clk = ~clk;

    cbr_resolver #(.AW(AW), .CW(CW)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_insn(in_insn), .in_pc(in_pc),
        .in_flag_n(fn), .in_flag_z(fz), .in_flag_c(fc), .in_flag_v(fv),
        .cost_base(cb), .cost_nseq(cn), .cost_seq(cs),
        .out_valid(out_valid), .out_taken(out_taken), .out_fetch_addr(out_fetch_addr),
        .out_pc_next(out_pc_next), .out_cycles(out_cycles),
        .out_undef(out_undef), .out_swi(out_swi)
    );

    function automatic logic ref_taken(input logic [3:0] k, input logic n, z, c, v);
        case (k)
            4'd0:  return z;             // R3
            4'd1:  return !z;
            4'd2:  return c;
            4'd3:  return !c;
            4'd4:  return n;
            4'd5:  return !n;
            4'd6:  return v;
            4'd7:  return !v;
            4'd8:  return c && !z;       // R4
            4'd9:  return !c || z;
            4'd10: return n == v;        // R5
            4'd11: return n != v;
            4'd12: return !z && (n == v); // R6
            4'd13: return z || (n != v);
            default: return 1'b0;        // R10
        endcase
    endfunction

    function automatic string code_tag(input logic [3:0] k);
        if (k < 4'd8)  return "R3";
        if (k < 4'd10) return "R4";
        if (k < 4'd12) return "R5";
        if (k < 4'd14) return "R6";
        return "R10";
    endfunction

    task automatic send(input logic [15:0] insn, input logic [31:0] pc,
                        input logic [3:0] nzcv, input logic [7:0] b, nq, sq);
        exp_t e;
        logic [31:0] tgt;
        logic [3:0]  k;
        @(negedge clk);
        in_valid = 1'b1; in_insn = insn; in_pc = pc;
        {fn, fz, fc, fv} = nzcv;
        cb = b; cn = nq; cs = sq;
        k = insn[11:8];
        tgt = pc + {{23{insn[7]}}, insn[7:0], 1'b0};
        e.code  = k;
        e.vld   = (insn[15:12] == 4'b1101);
        e.undef = e.vld && (k == 4'he);
        e.swi   = e.vld && (k == 4'hf);
        e.taken = e.vld && ref_taken(k, nzcv[3], nzcv[2], nzcv[1], nzcv[0]);
        e.fetch = e.taken ? tgt : pc;
        e.pcn   = e.taken ? tgt + 32'd2 : pc;
        if (!e.vld || e.undef || e.swi) e.cyc = '0;
        else if (e.taken) e.cyc = 10'(b) + 10'(nq) + 10'(sq) + 10'd2;
        else e.cyc = 10'(b);
        q.push_back(e);
    endtask

    // monitor: pops one expected item per result cycle
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (mon_on) begin
                if (q.size() > 0) begin
                    exp_t e;
                    bit   bad;
                    e = q.pop_front();
                    bad = 0;
                    n_cmp++;
                    if (out_valid !== e.vld) begin
                        bad = 1;
                        $display("FAIL R2 valid: actual %0b expected %0b", out_valid, e.vld);
                    end
                    if (e.vld) begin
                        if (out_taken !== e.taken) begin
                            bad = 1;
                            $display("FAIL %s taken code %0d: actual %0b expected %0b",
                                     code_tag(e.code), e.code, out_taken, e.taken);
                        end
                        if (out_undef !== e.undef || out_swi !== e.swi) begin
                            bad = 1;
                            $display("FAIL R10 flags: actual %0b%0b expected %0b%0b",
                                     out_undef, out_swi, e.undef, e.swi);
                        end
                        if (out_fetch_addr !== e.fetch || out_pc_next !== e.pcn) begin
                            bad = 1;
                            $display("FAIL %s addr: actual %h/%h expected %h/%h",
                                     e.taken ? "R7" : "R8", out_fetch_addr, out_pc_next,
                                     e.fetch, e.pcn);
                        end
                        if (out_cycles !== e.cyc) begin
                            bad = 1;
                            $display("FAIL R9 cycles: actual %0d expected %0d", out_cycles, e.cyc);
                        end
                    end else if (out_taken || out_undef || out_swi) begin
                        bad = 1;
                        $display("FAIL R2 quiet: actual %0b%0b%0b expected 000",
                                 out_taken, out_undef, out_swi);
                    end
                    if (32'(out_taken) + 32'(out_undef) + 32'(out_swi) > 1) begin
                        bad = 1;
                        $display("FAIL R11 outcomes: actual %0b%0b%0b expected at most one",
                                 out_taken, out_undef, out_swi);
                    end
                    if (bad) n_bad++;
                end else if (out_valid) begin
                    n_cmp++;
                    n_bad++;
                    $display("FAIL R2 unexpected result: actual 1 expected 0");
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: branch presented during reset must not appear
        @(negedge clk);
        in_valid = 1'b1; in_insn = 16'hD005; in_pc = 32'h100; fz = 1;
        repeat (3) @(posedge clk);
        #1;
        n_cmp++;
        if (out_valid !== 0 || out_taken !== 0 || out_undef !== 0 || out_swi !== 0 ||
            out_cycles !== 0) begin
            n_bad++;
            $display("FAIL R1 reset: actual %0b%0b%0b%0b/%0d expected 0000/0",
                     out_valid, out_taken, out_undef, out_swi, out_cycles);
        end
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b0;
        mon_on = 1;

        // full sweep: every code against every flag pattern (R3..R10)
        for (int k = 0; k < 16; k++) begin
            for (int f = 0; f < 16; f++) begin
                logic [7:0] off;
                off = 8'((k * 16 + f) * 37 + 5);
                send({4'b1101, 4'(k), off}, 32'h0800_0000 + 32'(k << 8) + 32'(f << 2),
                     4'(f), 8'(1 + f), 8'(2 + k), 8'(1 + (f & 3)));
            end
        end

        // R7 boundaries: largest forward, largest backward, wrap below zero
        send(16'hD07F, 32'h0000_1000, 4'b0100, 8'd1, 8'd3, 8'd1);
        send(16'hD080, 32'h0000_1000, 4'b0100, 8'd1, 8'd3, 8'd1);
        send(16'hD0FE, 32'h0000_0002, 4'b0100, 8'd1, 8'd3, 8'd1);
        send(16'hD100, 32'hFFFF_FFFE, 4'b0000, 8'd1, 8'd3, 8'd1);
        // R9: maximum costs, taken and not taken
        send(16'hD210, 32'h2000_0000, 4'b0010, 8'hFF, 8'hFF, 8'hFF);
        send(16'hD210, 32'h2000_0000, 4'b0000, 8'hFF, 8'hFF, 8'hFF);
        // R2: foreign opcodes are ignored, mixed with branches
        send(16'h4600, 32'h3000_0000, 4'b1111, 8'd4, 8'd4, 8'd4);
        send(16'hE0FF, 32'h3000_0000, 4'b1111, 8'd4, 8'd4, 8'd4);
        send(16'hC0FE, 32'h3000_0000, 4'b1111, 8'd4, 8'd4, 8'd4);
        send(16'hDF01, 32'h3000_0000, 4'b1111, 8'd4, 8'd4, 8'd4);
        send(16'hDE01, 32'h3000_0000, 4'b1111, 8'd4, 8'd4, 8'd4);
        @(negedge clk);
        in_valid = 1'b0;
        in_insn = 16'hD000;
        // R2: in_valid low gives no result
        repeat (4) @(negedge clk);
        n_cmp++;
        if (q.size() != 0) begin
            n_bad++;
            $display("FAIL R2 drain: actual %0d pending expected 0", q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule